// File: doc/BRIEF.md
# Display Timing Register Bank

This block holds the timing configuration of one display pipe. A mode is given as four counts per axis: visible (active) size, front porch, sync pulse width and blanking length. For each axis the block works out where sync begins and ends and how long the whole line or frame is. It packs those results into 32-bit timing words and stores them when a load strobe arrives. Every stored field is its count minus one. The starting value of each pair goes in the lower 16 bits and the ending value or total goes in the upper 16 bits.

A small write bus can also overwrite any timing word directly, and it programs a pipe configuration word. Bit 31 of that word means the pipe is enabled. Bit 30 reads back the pipe's live activity input. While either of those is set, the timing words are frozen. A load or bus write aimed at them is dropped and raises a sticky error flag. Reading the status address returns the flag and clears it.

A source-size word gives the visible frame size in the opposite half order: vertical in the lower half, horizontal in the upper half. Reads are combinational on the read address.

Top module: `disp_timing_bank`

## Requirements
- R1: After reset, all seven timing words and the pipe configuration word read 0, and the error flag is 0.
- R2: On an accepted load, the horizontal total word (address 0) and the vertical total word (address 3) hold active-1 in bits 15:0 and (active+blanking)-1 in bits 31:16.
- R3: On an accepted load, the horizontal blank word (address 1) and the vertical blank word (address 4) hold active-1 in bits 15:0 and (active+blanking)-1 in bits 31:16. Blanking begins right after the active region and ends at the total.
- R4: On an accepted load, the horizontal sync word (address 2) and the vertical sync word (address 5) hold (active+front)-1 in bits 15:0 and (active+front+sync)-1 in bits 31:16.
- R5: On an accepted load, the source-size word (address 6) holds vertical active-1 in bits 15:0 and horizontal active-1 in bits 31:16.
- R6: When unlocked, a bus write to any address 0 to 6 stores the written word unchanged at that address.
- R7: The bank is locked while configuration bit 31 is 1 or the pipe activity input is 1. While locked, a load or a bus write to addresses 0 to 6 leaves every timing word unchanged.
- R8: A bus write to address 7 is accepted whether or not the bank is locked. A read of address 7 returns the stored word with bit 30 replaced by the current pipe activity input.
- R9: A dropped load or timing write sets the error flag. A read of address 8 returns the flag in bit 0 with bits 31:1 at 0, and the flag clears at the clock edge of that read. A drop in the same cycle as the read leaves the flag set.
- R10: If a load and a bus write to a timing address fall in the same unlocked cycle, the loaded values are stored and the bus word is discarded.
- R11: All minus-one and sum arithmetic wraps modulo 2^16. For example, an active count of 0 stores 0xFFFF.
- R12: Reads of addresses 9 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load all seven timing words from the mode inputs |
| h_active | input | 16 | Horizontal visible pixels |
| h_front | input | 16 | Horizontal front porch pixels |
| h_sync | input | 16 | Horizontal sync width pixels |
| h_blank | input | 16 | Horizontal blanking pixels |
| v_active | input | 16 | Vertical visible lines |
| v_front | input | 16 | Vertical front porch lines |
| v_sync | input | 16 | Vertical sync width lines |
| v_blank | input | 16 | Vertical blanking lines |
| pipe_active_i | input | 1 | Live pipe activity status |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 4 | Bus write address |
| wr_data | input | 32 | Bus write data |
| rd_en | input | 1 | Read strobe (a read of address 8 clears the error flag) |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational on rd_addr |
| err_o | output | 1 | Sticky error flag for a dropped timing update |

## Verification
Two things can happen in the same cycle: a locked update attempt that sets the error flag, and a status read that clears it. The bench first makes sure the flag is already set. Then, in one cycle, it drives a status read together with a load while configuration bit 31 holds the lock. It checks that the flag still reads 1 afterwards. A second status read with nothing else going on must then clear it.

A second collision is a load and a bus timing write in one unlocked cycle. The bench judges it by reading back the loaded value, not the bus word.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
  localparam int ADDR_W  = 4;
  localparam int NUM_TIM = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_HTOT = 4'd0,
    A_HBLK = 4'd1,
    A_HSYN = 4'd2,
    A_VTOT = 4'd3,
    A_VBLK = 4'd4,
    A_VSYN = 4'd5,
    A_SRC  = 4'd6,
    A_PCFG = 4'd7,
    A_STAT = 4'd8
  } reg_addr_e;

  localparam int CFG_EN_BIT  = 31;
  localparam int CFG_ACT_BIT = 30;
endpackage

// File: rtl/axis_calc.sv
module axis_calc #(
  parameter int CNT_W = 16,
  localparam int WORD_W = 2 * CNT_W
) (
  input  logic [CNT_W-1:0]  active,
  input  logic [CNT_W-1:0]  front,
  input  logic [CNT_W-1:0]  sync_w,
  input  logic [CNT_W-1:0]  blank,
  output logic [WORD_W-1:0] tot_word,
  output logic [WORD_W-1:0] blk_word,
  output logic [WORD_W-1:0] syn_word,
  output logic [CNT_W-1:0]  act_m1
);
  function automatic logic [CNT_W-1:0] m1(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  function automatic logic [WORD_W-1:0] pair(input logic [CNT_W-1:0] lo,
                                             input logic [CNT_W-1:0] hi);
    return {m1(hi), m1(lo)};
  endfunction

  logic [CNT_W-1:0] sync_beg, sync_fin, total;

  always_comb begin
    sync_beg = active + front;
    sync_fin = sync_beg + sync_w;
    total    = active + blank;
    tot_word = pair(active, total);
    blk_word = pair(active, total);
    syn_word = pair(sync_beg, sync_fin);
    act_m1   = m1(active);
  end
endmodule

// File: rtl/write_guard.sv
module write_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic lock,
  input  logic attempt,
  input  logic clr_req,
  output logic accept,
  output logic reject,
  output logic err_q
);
  assign accept = attempt && !lock;
  assign reject = attempt && lock;

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (reject)  err_q <= 1'b1;
    else if (clr_req) err_q <= 1'b0;
  end

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err_q);
  // R9
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !reject) |=> !err_q);
  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(reject));
endmodule

// File: rtl/disp_timing_bank.sv
module disp_timing_bank
  import disp_timing_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  h_active,
  input  logic [CNT_W-1:0]  h_front,
  input  logic [CNT_W-1:0]  h_sync,
  input  logic [CNT_W-1:0]  h_blank,
  input  logic [CNT_W-1:0]  v_active,
  input  logic [CNT_W-1:0]  v_front,
  input  logic [CNT_W-1:0]  v_sync,
  input  logic [CNT_W-1:0]  v_blank,
  input  logic              pipe_active_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_o
);
  logic [CNT_W-1:0]  ax_act [2];
  logic [CNT_W-1:0]  ax_fp  [2];
  logic [CNT_W-1:0]  ax_sw  [2];
  logic [CNT_W-1:0]  ax_bl  [2];
  logic [DATA_W-1:0] ax_tot [2];
  logic [DATA_W-1:0] ax_blk [2];
  logic [DATA_W-1:0] ax_syn [2];
  logic [CNT_W-1:0]  ax_am1 [2];

  assign ax_act[0] = h_active; assign ax_act[1] = v_active;
  assign ax_fp[0]  = h_front;  assign ax_fp[1]  = v_front;
  assign ax_sw[0]  = h_sync;   assign ax_sw[1]  = v_sync;
  assign ax_bl[0]  = h_blank;  assign ax_bl[1]  = v_blank;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    axis_calc #(.CNT_W(CNT_W)) u_calc (
      .active  (ax_act[a]),
      .front   (ax_fp[a]),
      .sync_w  (ax_sw[a]),
      .blank   (ax_bl[a]),
      .tot_word(ax_tot[a]),
      .blk_word(ax_blk[a]),
      .syn_word(ax_syn[a]),
      .act_m1  (ax_am1[a])
    );
  end

  logic [DATA_W-1:0] ld_word [NUM_TIM];
  always_comb begin
    ld_word[A_HTOT] = ax_tot[0];
    ld_word[A_HBLK] = ax_blk[0];
    ld_word[A_HSYN] = ax_syn[0];
    ld_word[A_VTOT] = ax_tot[1];
    ld_word[A_VBLK] = ax_blk[1];
    ld_word[A_VSYN] = ax_syn[1];
    ld_word[A_SRC]  = {ax_am1[0], ax_am1[1]};
  end

  logic [DATA_W-1:0] treg_q [NUM_TIM];
  logic [DATA_W-1:0] cfg_q;
  logic lock, tim_wr, attempt, clr_req, accept, reject;

  assign lock    = cfg_q[CFG_EN_BIT] || pipe_active_i;
  assign tim_wr  = wr_en && (wr_addr < ADDR_W'(NUM_TIM));
  assign attempt = load_en || tim_wr;
  assign clr_req = rd_en && (rd_addr == A_STAT);

  write_guard u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock   (lock),
    .attempt(attempt),
    .clr_req(clr_req),
    .accept (accept),
    .reject (reject),
    .err_q  (err_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TIM; i++) treg_q[i] <= '0;
      cfg_q <= '0;
    end else begin
      if (accept) begin
        for (int i = 0; i < NUM_TIM; i++) begin
          if (load_en)                          treg_q[i] <= ld_word[i];
          else if (wr_addr == ADDR_W'(i))       treg_q[i] <= wr_data;
        end
      end
      if (wr_en && wr_addr == A_PCFG) cfg_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(NUM_TIM)) rd_data = treg_q[rd_addr[2:0]];
    else if (rd_addr == A_PCFG) begin
      rd_data = cfg_q;
      rd_data[CFG_ACT_BIT] = pipe_active_i;
    end else if (rd_addr == A_STAT) rd_data = {{(DATA_W-1){1'b0}}, err_o};
  end

  for (genvar r = 0; r < NUM_TIM; r++) begin : g_hold
    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(treg_q[r]));
  end

  // R8
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_PCFG) |=> (cfg_q == $past(wr_data)));
endmodule

// File: tb/disp_timing_bank_tb.sv
module disp_timing_bank_tb;
  logic clk = 0, rst_n = 0;
  logic load_en = 0, pipe_active_i = 0, wr_en = 0, rd_en = 0;
  logic [15:0] h_active = 0, h_front = 0, h_sync = 0, h_blank = 0;
  logic [15:0] v_active = 0, v_front = 0, v_sync = 0, v_blank = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        err_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  disp_timing_bank u_dut (.*);

  function automatic logic [31:0] pk(input int lo, input int hi);
    logic [15:0] l, h;
    l = 16'(lo - 1);
    h = 16'(hi - 1);
    return {h, l};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = 4'(a); #0.5; d = rd_data;
  endtask

  task automatic set_mode(input int ha, hf, hs, hb, va, vf, vs, vb);
    h_active = 16'(ha); h_front = 16'(hf); h_sync = 16'(hs); h_blank = 16'(hb);
    v_active = 16'(va); v_front = 16'(vf); v_sync = 16'(vs); v_blank = 16'(vb);
  endtask

  task automatic do_load();
    load_en = 1; tick(); load_en = 0;
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = 4'(a); wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic check_mode(input int ha, hf, hs, hb, va, vf, vs, vb);
    logic [31:0] d;
    rd(0, d); chk("R2 htot", d, pk(ha, ha+hb));
    rd(3, d); chk("R2 vtot", d, pk(va, va+vb));
    rd(1, d); chk("R3 hblk", d, pk(ha, ha+hb));
    rd(4, d); chk("R3 vblk", d, pk(va, va+vb));
    rd(2, d); chk("R4 hsyn", d, pk(ha+hf, ha+hf+hs));
    rd(5, d); chk("R4 vsyn", d, pk(va+vf, va+vf+vs));
    rd(6, d); chk("R5 src", d, {16'(ha-1), 16'(va-1)});
  endtask

  initial begin
    #(200000*4);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int ha_l[4] = '{1, 2, 640, 1920};
    int fp_l[3] = '{0, 1, 16};
    int sw_l[2] = '{1, 96};
    int bl_l[2] = '{1, 160};
    tick(); tick(); rst_n = 1; #0.5;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(a, d); chk("R1 reset", d, 0); end
    chk("R1 err", {31'b0, err_o}, 0);
    // R2 R3 R4 R5 sweep
    foreach (ha_l[i]) foreach (fp_l[j]) foreach (sw_l[k]) foreach (bl_l[m]) begin
      int va = ha_l[3-i] / 2 + 1;
      set_mode(ha_l[i], fp_l[j], sw_l[k], bl_l[m], va, fp_l[2-j], sw_l[1-k], bl_l[1-m] + 3);
      do_load();
      check_mode(ha_l[i], fp_l[j], sw_l[k], bl_l[m], va, fp_l[2-j], sw_l[1-k], bl_l[1-m] + 3);
    end
    chk("R9 no err when unlocked", {31'b0, err_o}, 0);
    // R11 wrap
    set_mode(0, 0, 0, 0, 65535, 1, 0, 2); do_load();
    rd(0, d); chk("R11 wrap htot", d, 32'hFFFF_FFFF);
    rd(5, d); chk("R11 wrap vsyn", d, 32'hFFFF_FFFF);
    rd(3, d); chk("R11 wrap vtot", d, {16'h0000, 16'hFFFE});
    // R6 direct writes
    for (int a = 0; a < 7; a++) begin
      bus_wr(a, 32'hA5000000 + 32'(a) * 32'h111);
      rd(a, d); chk("R6 direct", d, 32'hA5000000 + 32'(a) * 32'h111);
    end
    // R10 load beats bus write
    set_mode(800, 40, 128, 256, 600, 1, 4, 28);
    load_en = 1; wr_en = 1; wr_addr = 0; wr_data = 32'hDEADBEEF; tick();
    load_en = 0; wr_en = 0;
    rd(0, d); chk("R10 load priority", d, pk(800, 1056));
    // R8 config readback
    bus_wr(7, 32'h4000_0123); rd(7, d); chk("R8 cfg bit30 from input", d, 32'h0000_0123);
    pipe_active_i = 1; rd(7, d); chk("R8 cfg bit30 live", d, 32'h4000_0123);
    // R7 lock via activity input
    bus_wr(2, 32'h1234_5678);
    rd(2, d); chk("R7 locked write dropped", d, pk(840, 968));
    chk("R9 err set", {31'b0, err_o}, 1);
    // R9 read and clear
    rd_en = 1; rd(8, d); chk("R9 status read", d, 1); tick(); rd_en = 0;
    chk("R9 cleared", {31'b0, err_o}, 0);
    pipe_active_i = 0;
    // R7 lock via enable bit, R8 cfg written while locked
    bus_wr(7, 32'h8000_0000);
    set_mode(1, 1, 1, 1, 1, 1, 1, 1); do_load();
    rd(0, d); chk("R7 locked load dropped", d, pk(800, 1056));
    rd(6, d); chk("R7 src unchanged", d, {16'd799, 16'd599});
    bus_wr(7, 32'h8000_0005); rd(7, d); chk("R8 cfg write while locked", d, 32'h8000_0005);
    // R9 set wins over clear
    rd_en = 1; rd_addr = 8; load_en = 1; tick(); rd_en = 0; load_en = 0;
    chk("R9 set wins", {31'b0, err_o}, 1);
    rd_en = 1; rd_addr = 8; tick(); rd_en = 0;
    chk("R9 clear after", {31'b0, err_o}, 0);
    // R12 unmapped
    for (int a = 9; a < 16; a++) begin rd(a, d); chk("R12 unmapped", d, 0); end
    // unlock, load works again
    bus_wr(7, 0); set_mode(3, 2, 1, 5, 4, 1, 1, 2); do_load();
    check_mode(3, 2, 1, 5, 4, 1, 1, 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule